// File: doc/BRIEF.md
# Envelope Min-Max Latch Bank

This block sits behind a converter that delivers 8-bit samples time-multiplexed over a fixed rotation of four slots. The slots belong to two channels, and each channel has a maximum slot and a minimum slot. Every slot owns a holding register. After each accepted sample the bank presents on its output the slot's held byte, together with a tag that names the slot. Downstream storage can then save the bytes in arrival order without losing track of which channel and which extreme each byte belongs to.

In the continuous modes every arriving byte overwrites its slot. In envelope mode a slot takes the new byte only when that byte is a new extreme:
- A max slot takes it only if it is strictly greater than the held value.
- A min slot takes it only if it is strictly smaller than the held value.

The comparison is always made against that slot's own held value. An envelope restart preloads every max slot with all zeros and every min slot with all ones, so the first sample of a new envelope always lands. The latch write is modelled one cycle after the sample arrives, which stands in for a strobe phase-shifted from the converter clock.

Top module: `env_latch_bank`

## Requirements
- R1: The slot counter starts at 0 and advances by one on each accepted sample, wrapping after 3, and holds while `smp_valid` is low. Tag encoding on `out_slot`: 0 = channel-1 max, 1 = channel-2 max, 2 = channel-1 min, 3 = channel-2 min.
- R2: A sample accepted at a rising edge makes `out_valid` high for exactly one cycle, from the second rising edge after it. Samples accepted back to back give outputs back to back.
- R3: With `mode` = 2'b00 (normal), 2'b01 (average) or 2'b11 (treated as continuous), every accepted byte is written to its slot, and `out_data` equals that byte.
- R4: With `mode` = 2'b10 (envelope) at the accepting edge, a max slot (tags 0 and 1) is written only when the new byte is strictly greater than its held value. `out_data` is the slot's held value after that decision.
- R5: In envelope mode, a min slot (tags 2 and 3) is written only when the new byte is strictly smaller than its held value. `out_data` is the slot's held value after that decision.
- R6: In envelope mode each sample is compared only with the held value of its own slot. A byte written to one slot never changes the outcome for another slot.
- R7: `env_restart` does all of the following:
  - It preloads max slots with 8'h00 and min slots with 8'hFF.
  - It returns the slot counter to 0.
  - It discards any sample accepted in the same cycle or still in flight.
  - It forces `out_valid` low at the next edge.
- R8: After `rst_n` is released the bank is in the same state as after a restart, and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is present on `smp_data` this cycle |
| smp_data | input | 8 | Digitized sample byte |
| mode | input | 2 | Acquisition mode: 2'b10 envelope, all other codes continuous |
| env_restart | input | 1 | Start a new envelope: preload slots and reset the rotation |
| out_valid | output | 1 | `out_data` and `out_slot` carry a fresh result |
| out_data | output | 8 | Held byte of the slot just processed |
| out_slot | output | 2 | Tag of the slot just processed |

## Verification
The properties assume three things about the inputs:
- `mode` is the value in force at the edge that accepts a sample.
- Any sample that a restart does not discard reaches the output two edges later.
- The bounds are meaningful only once the pipeline has seen two edges since reset.

The stimulus drives `mode`, data and strobes on the falling edge, so each input is stable across the sampling edge. It changes `mode` only between samples. It lets the pipeline drain before each restart or reset, except in the cases that deliberately put a restart on, or right after, a sample in order to check that the sample is dropped.

// File: rtl/env_lb_pkg.sv
package env_lb_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'b00,
      MODE_AVERAGE  = 2'b01,
      MODE_ENVELOPE = 2'b10,
      MODE_SPARE    = 2'b11
   } acq_mode_e;

   function automatic logic mode_is_env(input logic [1:0] m);
      return m == MODE_ENVELOPE;
   endfunction

endpackage

// File: rtl/env_slot_seq.sv
// Slot rotation counter and one-cycle capture stage (models the shifted latch strobe).
module env_slot_seq #(
   parameter int DATA_W    = 8,
   parameter int NUM_SLOTS = 4,
   parameter int SLOT_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [1:0]        mode,
   output logic              cap_vld,
   output logic [DATA_W-1:0] cap_data,
   output logic [SLOT_W-1:0] cap_slot,
   output logic              cap_env
);
   import env_lb_pkg::*;

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   logic [SLOT_W-1:0] slot_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_cnt <= '0;
         cap_vld  <= 1'b0;
         cap_data <= '0;
         cap_slot <= '0;
         cap_env  <= 1'b0;
      end else if (restart) begin
         slot_cnt <= '0;
         cap_vld  <= 1'b0;
      end else begin
         cap_vld <= smp_valid;
         if (smp_valid) begin
            cap_data <= smp_data;
            cap_slot <= slot_cnt;
            cap_env  <= mode_is_env(mode);
            slot_cnt <= (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/env_slot_latch.sv
// One holding latch with its own extreme comparator.
module env_slot_latch #(
   parameter int DATA_W = 8,
   parameter bit IS_MIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              sel,
   input  logic              env,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] held,
   output logic              wr
);
   localparam logic [DATA_W-1:0] PRELOAD = IS_MIN ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

   logic beyond;

   generate
      if (IS_MIN) begin : g_min
         assign beyond = din < held;
      end else begin : g_max
         assign beyond = din > held;
      end
   endgenerate

   assign wr = sel && (!env || beyond);

   always_ff @(posedge clk) begin
      if (!rst_n)       held <= PRELOAD;
      else if (restart) held <= PRELOAD;
      else if (wr)      held <= din;
   end

endmodule

// File: rtl/env_latch_bank.sv
module env_latch_bank #(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 2,
   localparam int NUM_SLOTS = 2 * NUM_CH,
   localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [1:0]        mode,
   input  logic              env_restart,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [SLOT_W-1:0] out_slot
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("env_latch_bank: DATA_W must be at least 2");
      end
      if (NUM_CH < 1 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("env_latch_bank: NUM_CH must be a power of two");
      end
   endgenerate

   logic              cap_vld;
   logic [DATA_W-1:0] cap_data;
   logic [SLOT_W-1:0] cap_slot;
   logic              cap_env;
   logic [DATA_W-1:0] held [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] slot_wr;

   env_slot_seq #(
      .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .restart(env_restart),
      .smp_valid(smp_valid), .smp_data(smp_data), .mode(mode),
      .cap_vld(cap_vld), .cap_data(cap_data), .cap_slot(cap_slot), .cap_env(cap_env)
   );

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         env_slot_latch #(
            .DATA_W(DATA_W), .IS_MIN(s >= NUM_CH)
         ) i_latch (
            .clk(clk), .rst_n(rst_n), .restart(env_restart),
            .sel(cap_vld && (cap_slot == SLOT_W'(s))),
            .env(cap_env), .din(cap_data),
            .held(held[s]), .wr(slot_wr[s])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_slot  <= '0;
      end else if (env_restart) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= cap_vld;
         if (cap_vld) begin
            out_slot <= cap_slot;
            out_data <= (|slot_wr) ? cap_data : held[cap_slot];
         end
      end
   end

endmodule

// File: rtl/env_latch_bank_chk.sv
module env_latch_bank_chk #(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 2,
   parameter int SLOT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic [DATA_W-1:0] smp_data,
   input logic [1:0]        mode,
   input logic              env_restart,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [SLOT_W-1:0] out_slot
);
   import env_lb_pkg::*;

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(2 * NUM_CH - 1);

   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   logic warm;
   assign warm = since_rst == 2'd3;

   logic is_min_slot;
   assign is_min_slot = out_slot >= SLOT_W'(NUM_CH);

   AST_SLOT_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(out_valid)) |->
         out_slot == (($past(out_slot) == LAST_SLOT) ? '0 : $past(out_slot) + 1'b1)); // R1

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !env_restart) ##1 !env_restart |=> out_valid); // R2

   AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid) |-> $past(smp_valid, 2)); // R2

   AST_CONT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && !mode_is_env($past(mode, 2))) |-> out_data == $past(smp_data, 2)); // R3

   AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && mode_is_env($past(mode, 2)) && !is_min_slot) |->
         out_data >= $past(smp_data, 2)); // R4

   AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && mode_is_env($past(mode, 2)) && is_min_slot) |->
         out_data <= $past(smp_data, 2)); // R5

   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      env_restart |=> !out_valid); // R7

endmodule

bind env_latch_bank env_latch_bank_chk #(
   .DATA_W(DATA_W), .NUM_CH(NUM_CH), .SLOT_W(SLOT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
   .mode(mode), .env_restart(env_restart), .out_valid(out_valid),
   .out_data(out_data), .out_slot(out_slot)
);

// File: tb/test_env_latch_bank.sv
module test_env_latch_bank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic [7:0] smp_data = 8'h00;
   logic [1:0] mode = 2'b00;
   logic       env_restart = 1'b0;
   logic       out_valid;
   logic [7:0] out_data;
   logic [1:0] out_slot;

   env_latch_bank i_env_latch_bank (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .mode(mode), .env_restart(env_restart), .out_valid(out_valid),
      .out_data(out_data), .out_slot(out_slot)
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0] q_data[$];
   logic [1:0] q_slot[$];
   int         q_cyc[$];
   string      q_tag[$];

   logic [7:0] m_held[4];
   int         m_cnt;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      m_held[0] = 8'h00; m_held[1] = 8'h00;
      m_held[2] = 8'hFF; m_held[3] = 8'hFF;
      m_cnt = 0;
   endtask

   // Driver: puts one sample on the inputs and pushes the expected result.
   task automatic send(input logic [7:0] d, input string tag);
      bit env, is_min, take;
      smp_valid = 1'b1;
      smp_data  = d;
      env    = (mode == 2'b10);
      is_min = m_cnt >= 2;
      take   = !env || (is_min ? (d < m_held[m_cnt]) : (d > m_held[m_cnt]));
      if (take) m_held[m_cnt] = d;
      q_data.push_back(m_held[m_cnt]);
      q_slot.push_back(2'(m_cnt));
      q_cyc.push_back(cyc + 2);
      q_tag.push_back(tag);
      m_cnt = (m_cnt + 1) % 4;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic restart();
      env_restart = 1'b1;
      model_clear();
      @(negedge clk);
      env_restart = 1'b0;
   endtask

   // Monitor: pops and compares every result the design produces.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_data.size() == 0) begin
            check(1'b0, "R7 unexpected output", int'(out_data), -1);
         end else begin
            logic [7:0] ed; logic [1:0] es; int ec; string et;
            ed = q_data.pop_front(); es = q_slot.pop_front();
            ec = q_cyc.pop_front();  et = q_tag.pop_front();
            check(out_data == ed, et, int'(out_data), int'(ed));
            check(out_slot == es, "R1 slot tag", int'(out_slot), int'(es));
            check(cyc == ec, "R2 latency", cyc, ec);
         end
      end
   end

   initial begin
      fork
         begin
            model_clear();
            idle(3);
            rst_n = 1'b1;
            idle(1);
            check(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
            check(out_slot == 2'd0, "R8 reset slot", int'(out_slot), 0);

            // R3: continuous modes with back-to-back samples and idle gaps (R1 holds on idle)
            mode = 2'b00;
            for (int i = 0; i < 8; i++) send(8'((i * 53 + 7) & 8'hFF), "R3 normal");
            mode = 2'b01;
            for (int i = 0; i < 5; i++) begin send(8'(200 - i * 31), "R3 average"); idle(i % 3); end
            mode = 2'b11;
            for (int i = 0; i < 4; i++) send(8'(i * 9), "R3 spare code");
            idle(4);

            // R4/R5: envelope growth after restart
            restart();
            mode = 2'b10;
            for (int i = 0; i < 24; i++) send(8'((i * 37 + 11) & 8'hFF), "R4/R5 envelope");
            idle(2);
            for (int i = 0; i < 8; i++) send(8'h80, "R4/R5 equal or inside");
            idle(4);

            // R6: large value on channel-2 max must not block a small value on channel-1 max
            restart();
            send(8'h10, "R6 ch1 max");
            send(8'hF0, "R6 ch2 max");
            send(8'hE0, "R6 ch1 min");
            send(8'h05, "R6 ch2 min");
            send(8'h20, "R6 ch1 max own compare");
            send(8'hA0, "R6 ch2 max no write");
            send(8'hE1, "R6 ch1 min no write");
            send(8'h04, "R6 ch2 min own compare");
            idle(4);

            // R7: restart mid rotation returns the counter to slot 0
            send(8'h33, "R7 pre restart");
            send(8'h44, "R7 pre restart");
            idle(4);
            restart();
            send(8'h01, "R7 first after restart");
            send(8'h02, "R7 second after restart");
            idle(4);

            // R7: restart one cycle after a sample drops it
            smp_valid = 1'b1; smp_data = 8'h77;
            @(negedge clk);
            smp_valid = 1'b0;
            restart();
            idle(4);
            // R7: restart in the same cycle as a sample drops it
            smp_valid = 1'b1; smp_data = 8'h66;
            restart();
            smp_valid = 1'b0;
            idle(4);
            send(8'h09, "R7 slot 0 after drops");
            idle(4);

            // R3: leaving envelope mode overwrites the held extremes
            mode = 2'b00;
            for (int i = 0; i < 4; i++) send(8'h55, "R3 after envelope");
            idle(4);

            // R8: a second reset preloads like a restart
            rst_n = 1'b0;
            idle(2);
            rst_n = 1'b1;
            model_clear();
            check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
            mode = 2'b10;
            send(8'h01, "R8 max preload");
            send(8'h00, "R8 max preload equal");
            send(8'hFE, "R8 min preload");
            send(8'hFF, "R8 min preload equal");
            idle(5);

            check(q_data.size() == 0, "R2 all results seen", q_data.size(), 0);
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog", cyc, 0);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule